// File: doc/BRIEF.md
# Bus Master Transaction Start Controller

This block is the master-side sequencer of a device on a shared, parallel, multi-drop bus whose control lines are active low. It decides the clock in which the device may open a transaction, then steps through the address phase and the data phases and releases the bus again. The cycle-framing line and the initiator-ready line are driven through the two drive enables this block produces, and the bus values of both lines are fed back to it for idle detection.

A start is allowed only when several conditions all hold in the same clock. The master must be enabled and must have a request pending. Its own grant line must be low. Both the framing line and the initiator-ready line, as seen live on the bus in that clock, must be high. The framing line is examined without any register stage. Another master may open a cycle in the very clock in which the grant moves to this device, or may restart immediately after its last data phase (a fast back-to-back cycle). A copy delayed by one clock would miss either of these and let two masters drive the bus at once.

Once started, the framing enable is raised first. The initiator-ready enable follows one clock later. The framing enable drops when the final data phase begins, and the initiator-ready enable drops one clock after that, when that phase ends. Each data phase takes one clock.

Top module: `bmc_master_start`

## Requirements
- R1: After reset, and whenever reset is applied during a transaction, `frame_oe`, `irdy_oe` and `busy` are 0 on the next observation.
- R2: When `en`, `req`, `gnt_n`=0, `frame_n`=1 and `irdy_n`=1 all hold at a rising clock edge in idle, then after that edge `frame_oe`=1, `irdy_oe`=0 and `busy`=1 (the address phase).
- R3: With `en`=0 no transaction starts, even if every other start condition holds.
- R4: With `gnt_n`=1 no transaction starts. The controller stays idle and still starts at a later edge where the grant is back.
- R5: If `frame_n`=0 at the edge, no transaction starts. This includes the edge at which the grant first appears while another master opens its cycle in that same clock.
- R6: If `irdy_n`=0 at the edge (another master is in its final data phase), no transaction starts.
- R7: If another master drives `frame_n` low in the clock right after its final data phase (`frame_n`=1, `irdy_n`=0), followed by `frame_n`=0, `irdy_n`=1, no transaction starts in either clock.
- R8: With `req`=0 no transaction starts.
- R9: One clock after the address phase, `irdy_oe`=1. `frame_oe` stays 1 unless `last` was 1 in the address phase.
- R10: When `last`=1 at an edge during a non-final data phase, after that edge `frame_oe`=0 and `irdy_oe`=1.
- R11: One clock after the final data phase begins, `frame_oe`=0, `irdy_oe`=0 and `busy`=0.
- R12: When `last`=1 at the edge ending the address phase, the next clock is the final data phase: `frame_oe`=0 and `irdy_oe`=1.
- R13: While `busy`=1, the start inputs are ignored. No new address phase begins until the controller has returned to idle, including when all start conditions hold in the final data phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Master enable |
| req | input | 1 | Internal request to open a transaction |
| gnt_n | input | 1 | Grant from the arbiter, active low |
| frame_n | input | 1 | Live bus value of the framing line, active low |
| irdy_n | input | 1 | Live bus value of the initiator-ready line, active low |
| last | input | 1 | The data phase that begins at this edge is the final one |
| frame_oe | output | 1 | Drive the framing line low |
| irdy_oe | output | 1 | Drive the initiator-ready line low |
| busy | output | 1 | A transaction of this master is in progress |

## Verification
The start decision is tried with each of its five conditions withheld in turn while the other four hold. A grant that arrives in the same clock as a foreign framing assertion separates a live idle check from a one-clock-late one. The same is true of a foreign fast back-to-back restart, where the framing line falls again right after the initiator-ready line was low. Sequences with a single data phase, with several data phases, and with a start request held through the final phase separate correct framing and ready release timing from early, late or re-entrant starts.

// File: rtl/bmc_pkg.sv
package bmc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2,
        ST_LAST = 2'd3
    } bmc_state_t;

    typedef struct packed {
        bmc_state_t st;
        logic       frame_oe;
        logic       irdy_oe;
    } bmc_regs_t;

    localparam bmc_regs_t BMC_RESET = '{st: ST_IDLE, frame_oe: 1'b0, irdy_oe: 1'b0};

endpackage

// File: rtl/bmc_idle_detect.sv
module bmc_idle_detect (
    input  logic frame_n,
    input  logic irdy_n,
    output logic bus_idle
);
    // Both lines are taken straight from the bus in the current clock.
    // No register stage is allowed here: a one-clock-late framing view
    // hides a cycle that another master opens in this clock.
    always_comb begin
        bus_idle = frame_n & irdy_n;
    end
endmodule

// File: rtl/bmc_start_gate.sv
module bmc_start_gate (
    input  logic en,
    input  logic req,
    input  logic gnt_n,
    input  logic bus_idle,
    output logic start_ok
);
    always_comb begin
        start_ok = en & req & ~gnt_n & bus_idle;
    end
endmodule

// File: rtl/bmc_seq.sv
module bmc_seq
    import bmc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_ok,
    input  logic last,
    output logic frame_oe,
    output logic irdy_oe,
    output logic busy
);
    bmc_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                r_d.frame_oe = 1'b0;
                r_d.irdy_oe  = 1'b0;
                if (start_ok) begin
                    r_d.st       = ST_ADDR;
                    r_d.frame_oe = 1'b1;
                end
            end
            ST_ADDR, ST_DATA: begin
                r_d.irdy_oe = 1'b1;
                if (last) begin
                    r_d.st       = ST_LAST;
                    r_d.frame_oe = 1'b0;
                end else begin
                    r_d.st       = ST_DATA;
                    r_d.frame_oe = 1'b1;
                end
            end
            ST_LAST: begin
                r_d.st       = ST_IDLE;
                r_d.frame_oe = 1'b0;
                r_d.irdy_oe  = 1'b0;
            end
            default: r_d = BMC_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= BMC_RESET;
        else        r_q <= r_d;
    end

    assign frame_oe = r_q.frame_oe;
    assign irdy_oe  = r_q.irdy_oe;
    assign busy     = (r_q.st != ST_IDLE);

    // R9: ready follows the address phase by one clock
    p_irdy_after_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_ADDR) |=> irdy_oe);

    // R10: framing released while ready still held
    p_frame_before_irdy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_oe) |-> irdy_oe);

    // R11: ready released one clock after framing
    p_irdy_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_oe) |=> (!irdy_oe && !busy));

    // R13: no address phase directly after a busy clock
    p_no_reentry_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_LAST) |=> !frame_oe);
endmodule

// File: rtl/bmc_master_start.sv
module bmc_master_start (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic req,
    input  logic gnt_n,
    input  logic frame_n,
    input  logic irdy_n,
    input  logic last,
    output logic frame_oe,
    output logic irdy_oe,
    output logic busy
);
    logic bus_idle;
    logic start_ok;

    bmc_idle_detect u_idle (
        .frame_n  (frame_n),
        .irdy_n   (irdy_n),
        .bus_idle (bus_idle)
    );

    bmc_start_gate u_gate (
        .en       (en),
        .req      (req),
        .gnt_n    (gnt_n),
        .bus_idle (bus_idle),
        .start_ok (start_ok)
    );

    bmc_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_ok (start_ok),
        .last     (last),
        .frame_oe (frame_oe),
        .irdy_oe  (irdy_oe),
        .busy     (busy)
    );

    // R2/R5/R6: a new transaction opens only from a live-idle, granted clock
    p_start_conditions_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(en && req && !gnt_n && frame_n && irdy_n));

    // R2: address phase drives framing without ready
    p_addr_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (frame_oe && !irdy_oe));
endmodule

// File: tb/tb_bmc_master_start.sv
module tb_bmc_master_start;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, req = 1'b0, gnt_n = 1'b1, frame_n = 1'b1, irdy_n = 1'b1, last = 1'b0;
    logic frame_oe, irdy_oe, busy;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bmc_master_start dut (
        .clk(clk), .rst_n(rst_n), .en(en), .req(req), .gnt_n(gnt_n),
        .frame_n(frame_n), .irdy_n(irdy_n), .last(last),
        .frame_oe(frame_oe), .irdy_oe(irdy_oe), .busy(busy)
    );

    // {req, en, gnt_n, frame_n, irdy_n, last, exp_frame_oe, exp_irdy_oe, exp_busy}
    localparam logic [8:0] VEC [NVEC] = '{
        9'b011110_000,  // no request
        9'b100110_000,  // disabled
        9'b111110_000,  // no grant
        9'b110010_000,  // grant appears as other master frames
        9'b110100_000,  // other master final data phase
        9'b110010_000,  // other master fast back-to-back restart
        9'b111110_000,  // grant lost again, keep waiting
        9'b110110_101,  // start
        9'b011010_111,  // address -> data
        9'b011010_111,  // data continues
        9'b011001_011,  // final data phase
        9'b011110_000,  // back to idle
        9'b110110_101,  // start again
        9'b011011_011,  // single data phase
        9'b011110_000,  // idle
        9'b110110_101,  // start
        9'b110110_111,  // start inputs held while busy
        9'b110111_011,  // final phase
        9'b110110_000,  // start inputs held in final phase: no restart
        9'b010110_000   // conditions hold but no request
    };

    localparam logic [23:0] TAG [NVEC] = '{
        "R8 ", "R3 ", "R4 ", "R5 ", "R6 ", "R7 ", "R4 ", "R2 ", "R9 ", "R13",
        "R10", "R11", "R2 ", "R12", "R11", "R2 ", "R13", "R10", "R13", "R8 "
    };

    task automatic check(input logic [23:0] tag, input logic [2:0] act, input logic [2:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {frame_oe,irdy_oe,busy} = %b, expected %b", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [5:0] v);
        {req, en, gnt_n, frame_n, irdy_n, last} = v;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 ", {frame_oe, irdy_oe, busy}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ", {frame_oe, irdy_oe, busy}, 3'b000);

        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][8:3]);
            @(negedge clk);
            check(TAG[i], {frame_oe, irdy_oe, busy}, VEC[i][2:0]);
        end

        // R4: grant regained after a wait still starts
        drive(6'b111110);
        @(negedge clk);
        check("R4 ", {frame_oe, irdy_oe, busy}, 3'b000);
        drive(6'b110110);
        @(negedge clk);
        check("R4 ", {frame_oe, irdy_oe, busy}, 3'b101);

        // R1: reset in the middle of a transaction
        drive(6'b011010);
        @(negedge clk);
        check("R9 ", {frame_oe, irdy_oe, busy}, 3'b111);
        rst_n = 1'b0;
        #1;
        check("R1 ", {frame_oe, irdy_oe, busy}, 3'b000);
        @(negedge clk);
        rst_n = 1'b1;
        drive(6'b010110);
        @(negedge clk);
        check("R1 ", {frame_oe, irdy_oe, busy}, 3'b000);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule